// File: doc/BRIEF.md
# Serial Comma Word Aligner

This block sits behind a clock and data recovery stage. It receives one retimed bit in each clock cycle where `bit_en` is high. It packs the bits into 20-bit words, each holding two 10-bit characters, with the earliest bit at word bit 0. Holding `bit_en` low on alternate cycles gives half-rate operation, and the word strobe follows the accepted bits rather than the clock.

The block looks for the 7-bit synchronization comma in the newest seven received bits. In arrival order the comma is zero, zero, then five ones. When `align_en` is high, a comma makes the block restart its word count so that the comma occupies word bits 0 to 6. The partial word in progress at that moment is discarded. A comma that is already in the right place needs no change, so no data is lost. The word that carries the comma is output with `comma_flag` high for that word only. When `align_en` is low, the boundary never moves and the flag stays low.

Framing is held in a two-state machine. `FR_PLAIN` means the word being built has no accepted comma. `FR_MARKED` means the word being built started at a comma and will be flagged. The transitions are:
- `realign`: from either state to `FR_MARKED`, on a comma with `align_en` high.
- `emit_plain`: from `FR_PLAIN` back to `FR_PLAIN`, when the twentieth bit arrives.
- `emit_flagged`: from `FR_MARKED` to `FR_PLAIN`, when the twentieth bit arrives.
- `hold`: no change, on any other cycle.

Top module: `comma_word_aligner`

## Requirements
- R1: The first bit accepted after a word boundary appears at `word_out[0]`, and each later bit at the next higher position, up to bit 19.
- R2: Without a realignment, `word_valid` pulses for exactly one cycle, one cycle after every twentieth accepted bit, and never in two consecutive cycles.
- R3: In a cycle with `bit_en` low, `rx_bit` is ignored, the word count does not advance, `word_valid` stays low in the next cycle and `word_out` keeps its value.
- R4: A comma is the seven newest accepted bits reading 0,0,1,1,1,1,1 in arrival order. A flagged word therefore holds `word_out[6:0]` = 7'b1111100.
- R5: A comma that completes at word bit 6 (properly aligned) with `align_en` high leaves the boundary unchanged. Its word is output complete, with `comma_flag` high.
- R6: A comma at any other offset with `align_en` high, including one straddling a character or word boundary, restarts the word. The next word is output 13 accepted bits later, with the comma in bits 0 to 6 and the flag high, and the partial word is dropped.
- R7: While `align_en` is low, commas do not move the boundary, and a word whose bits were all taken with `align_en` low has `comma_flag` low.
- R8: `comma_flag` is high only together with `word_valid`, and for one word only.
- R9: After reset, `word_out` is zero, `word_valid` and `comma_flag` are low, and the next 20 accepted bits form the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | A serial bit is present this cycle |
| rx_bit | input | 1 | Retimed serial data bit |
| align_en | input | 1 | Enables comma flagging and word realignment |
| word_out | output | 20 | Deserialized word, earliest bit in bit 0 |
| word_valid | output | 1 | One-cycle strobe for a new word |
| comma_flag | output | 1 | The word on `word_out` carries a comma in bits 0 to 6 |

## Verification
The block is driven with several kinds of input:
- A known word with alignment off, which checks bit order.
- Alternating `bit_en`, which separates clock-count framing from bit-count framing.
- A comma already on the boundary, which must not lose data.
- A comma five bits off, which must drop the partial word.
- Commas with alignment off, which must leave the boundary fixed.

A long random stream then mixes idle cycles, toggled enables and commas inserted at random offsets, including ones that straddle words. Every output is compared each cycle against a bench reference model.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;

    // Comma code, bit i is the i-th bit in arrival order: 0,0,1,1,1,1,1
    localparam int unsigned COMMA_LEN = 7;
    localparam logic [COMMA_LEN-1:0] COMMA_CODE = 7'b1111100;

    typedef enum logic [0:0] {
        FR_PLAIN  = 1'b0,
        FR_MARKED = 1'b1
    } frame_state_t;

endpackage

// File: rtl/bit_window.sv
module bit_window #(
    parameter int unsigned WIN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    output logic [WIN_W-1:0] win_next
);

    logic [WIN_W-1:0] win_q;

    // Newest bit enters at the top; the oldest sits at bit 0
    assign win_next = bit_en ? {rx_bit, win_q[WIN_W-1:1]} : win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (bit_en) begin
            win_q <= win_next;
        end
    end

endmodule

// File: rtl/comma_match.sv
module comma_match #(
    parameter int unsigned WIN_W = 20,
    parameter int unsigned PAT_W = 7,
    parameter logic [PAT_W-1:0] PATTERN = 7'b1111100
) (
    input  logic [WIN_W-1:0] win,
    output logic             hit
);

    localparam int unsigned BASE = WIN_W - PAT_W;

    logic [PAT_W-1:0] bit_eq;

    // Compare the newest PAT_W bits, oldest of them against PATTERN[0]
    for (genvar i = 0; i < PAT_W; i++) begin : g_cmp
        assign bit_eq[i] = (win[BASE+i] == PATTERN[i]);
    end

    assign hit = &bit_eq;

endmodule

// File: rtl/word_framer.sv
module word_framer
    import comma_align_pkg::*;
#(
    parameter int unsigned WORD_W = 20,
    parameter int unsigned PAT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              align_en,
    input  logic              hit,
    input  logic [WORD_W-1:0] win_next,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              comma_flag
);

    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] RESTART  = CNT_W'(PAT_W);

    frame_state_t     state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             realign;
    logic             emit;

    // A comma always restarts the count at PAT_W; when it was already aligned
    // the count was PAT_W-1 and this equals a plain increment.
    assign realign = bit_en & align_en & hit;
    assign emit    = bit_en & ~realign & (cnt_q == LAST_POS);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            FR_PLAIN: begin
                if (realign) begin
                    state_nx = FR_MARKED;
                end
            end
            FR_MARKED: begin
                if (realign) begin
                    state_nx = FR_MARKED;
                end else if (emit) begin
                    state_nx = FR_PLAIN;
                end
            end
            default: state_nx = FR_PLAIN;
        endcase
    end

    always_comb begin
        if (realign) begin
            cnt_nx = RESTART;
        end else if (emit) begin
            cnt_nx = '0;
        end else if (bit_en) begin
            cnt_nx = cnt_q + 1'b1;
        end else begin
            cnt_nx = cnt_q;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_PLAIN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
            comma_flag <= 1'b0;
        end else begin
            word_valid <= emit;
            comma_flag <= emit && (state_q == FR_MARKED);
            if (emit) begin
                word_out <= win_next;
            end
        end
    end

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
    import comma_align_pkg::*;
#(
    parameter int unsigned WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              align_en,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              comma_flag
);

    logic [WORD_W-1:0] win_next;
    logic              comma_hit;

    bit_window #(.WIN_W(WORD_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .rx_bit   (rx_bit),
        .win_next (win_next)
    );

    comma_match #(
        .WIN_W   (WORD_W),
        .PAT_W   (COMMA_LEN),
        .PATTERN (COMMA_CODE)
    ) u_match (
        .win (win_next),
        .hit (comma_hit)
    );

    word_framer #(
        .WORD_W (WORD_W),
        .PAT_W  (COMMA_LEN)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .align_en   (align_en),
        .hit        (comma_hit & bit_en),
        .win_next   (win_next),
        .word_out   (word_out),
        .word_valid (word_valid),
        .comma_flag (comma_flag)
    );

endmodule

// File: rtl/comma_word_aligner_chk.sv
module comma_word_aligner_chk
    import comma_align_pkg::*;
#(
    parameter int unsigned WORD_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              align_en,
    input logic [WORD_W-1:0] word_out,
    input logic              word_valid,
    input logic              comma_flag
);

    localparam int unsigned GAP_W = $clog2(WORD_W) + 2;
    localparam logic [GAP_W-1:0] GAP_MAX  = '1;
    localparam logic [GAP_W-1:0] GAP_WORD = GAP_W'(WORD_W);

    logic [GAP_W-1:0] gap_q;
    logic             off_all_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q     <= '0;
            off_all_q <= 1'b1;
        end else if (word_valid) begin
            gap_q     <= bit_en ? GAP_W'(1) : '0;
            off_all_q <= bit_en ? !align_en : 1'b1;
        end else if (bit_en) begin
            gap_q     <= (gap_q == GAP_MAX) ? gap_q : gap_q + 1'b1;
            off_all_q <= off_all_q & !align_en;
        end
    end

    // R8
    flag_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        comma_flag |-> word_valid);

    // R4
    flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        comma_flag |-> (word_out[COMMA_LEN-1:0] == COMMA_CODE));

    // R2
    valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> (!word_valid && $stable(word_out)));

    // R7
    off_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && off_all_q) |-> (gap_q == GAP_WORD && !comma_flag));

endmodule

bind comma_word_aligner comma_word_aligner_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .align_en   (align_en),
    .word_out   (word_out),
    .word_valid (word_valid),
    .comma_flag (comma_flag)
);

// File: tb/comma_word_aligner_test.sv
module comma_word_aligner_test;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 20;
    localparam logic [9:0] COMMA_CHAR  = 10'b0101111100; // arrival 0011111010
    localparam logic [9:0] FILLER_CHAR = 10'b1101011001; // arrival 1001101011

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bit_en = 1'b0;
    logic              rx_bit = 1'b0;
    logic              align_en = 1'b0;
    logic [WORD_W-1:0] word_out;
    logic              word_valid;
    logic              comma_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state
    logic [WORD_W-1:0] m_win = '0;
    logic [WORD_W-1:0] m_word = '0;
    int                m_cnt = 0;
    bit                m_mark = 1'b0;
    bit                m_valid = 1'b0;
    bit                m_flag = 1'b0;
    string             last_req = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    comma_word_aligner #(.WORD_W(WORD_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .rx_bit     (rx_bit),
        .align_en   (align_en),
        .word_out   (word_out),
        .word_valid (word_valid),
        .comma_flag (comma_flag)
    );

    function automatic bit is_comma(input logic [WORD_W-1:0] w);
        return w[WORD_W-1 -: 7] == 7'b1111100;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        check(word_valid == m_valid, last_req, "word_valid (R2)", 32'(word_valid), 32'(m_valid));
        check(word_out == m_word, last_req, "word_out (R1)", 32'(word_out), 32'(m_word));
        check(comma_flag == m_flag, last_req, "comma_flag", 32'(comma_flag), 32'(m_flag));
        if (comma_flag) begin
            check(word_out[6:0] == 7'b1111100, "R4", "flagged word low bits",
                  32'(word_out[6:0]), 32'h7c);
            check(word_valid, "R8", "flag without strobe", 32'(word_valid), 32'd1);
        end
    endtask

    task automatic tick(input logic b, input logic en, input logic al, input string req);
        @(negedge clk);
        compare();
        rx_bit   = b;
        bit_en   = en;
        align_en = al;
        last_req = req;
        m_valid  = 1'b0;
        m_flag   = 1'b0;
        if (en) begin
            m_win = {b, m_win[WORD_W-1:1]};
            if (al && is_comma(m_win)) begin
                m_cnt  = 7;
                m_mark = 1'b1;
            end else if (m_cnt == WORD_W - 1) begin
                m_valid = 1'b1;
                m_word  = m_win;
                m_flag  = m_mark;
                m_mark  = 1'b0;
                m_cnt   = 0;
            end else begin
                m_cnt++;
            end
        end
    endtask

    task automatic send(input logic [19:0] v, input int n, input logic al,
                        input bit half, input string req);
        for (int i = 0; i < n; i++) begin
            if (half) tick(1'b1, 1'b0, al, req); // idle bit must be ignored
            tick(v[i], 1'b1, al, req);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1c0de);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(word_out == '0 && !word_valid && !comma_flag, "R9", "reset outputs",
              {word_valid, comma_flag, 10'd0, word_out}, 32'd0);

        // R1: known word, earliest bit at position 0
        send(20'h5A3C9, 20, 1'b0, 1'b0, "R1");
        tick(1'b0, 1'b0, 1'b0, "R1");
        check(word_out == 20'h5A3C9, "R1", "directed word", 32'(word_out), 32'h5A3C9);

        // R3: half-rate with ignored idle bits
        send(20'h0F0F3, 20, 1'b0, 1'b1, "R3");
        send(20'hC3A51, 20, 1'b0, 1'b1, "R3");

        // R5: comma already on the boundary
        for (int k = 0; k < 3; k++) send({FILLER_CHAR, COMMA_CHAR}, 20, 1'b1, 1'b0, "R5");

        // R6: comma shifted by five bits
        send(20'h00005, 5, 1'b1, 1'b0, "R6");
        for (int k = 0; k < 3; k++) send({FILLER_CHAR, COMMA_CHAR}, 20, 1'b1, 1'b0, "R6");

        // R7: alignment off, boundary must stay where it is
        send(20'h00002, 3, 1'b0, 1'b0, "R7");
        for (int k = 0; k < 3; k++) send({FILLER_CHAR, COMMA_CHAR}, 20, 1'b0, 1'b0, "R7");

        // Random mix: R2 R3 R5 R6 R7 R8
        for (int w = 0; w < 200; w++) begin
            logic al;
            bit half;
            al   = ($urandom % 4) != 0;
            half = ($urandom % 3) == 0;
            if (($urandom % 3) == 0) begin
                send(20'($urandom), int'($urandom % 13), al, half, "R6");
                send({FILLER_CHAR, COMMA_CHAR}, 20, al, half, "R6");
            end else begin
                for (int i = 0; i < 20; i++) begin
                    tick(1'($urandom), 1'($urandom % 4 != 0), al, "R2");
                end
            end
        end

        tick(1'b0, 1'b0, 1'b0, "R2");
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule